// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Controller

This block is a clock-accurate, synthesizable model of the control and data path of a byte-wide one-time-programmable memory. Five control inputs are sampled every cycle: an active-low select, an active-low read strobe, an active-low program strobe, and two flags. One flag stands for the high programming voltage. The other stands for the high identification voltage on address line 9. These five inputs are decoded into a single operating mode. The mode decides whether the data bus is driven. It also decides whether the bus carries a stored byte or a fixed identifier byte, and whether the addressed byte is programmed.

The array is a parameterized set of byte registers. Reset places every register in the erased, all-ones state. A program cycle can only clear bits, so a stored zero is permanent until the next reset. The data output and its drive enable are registered. The enable is meant to control an external tri-state pad. When the bus is not driven, the data output is held at zero.

Top module: `otp_byte_mem`

## Requirements
- R1: While reset is asserted, and directly after it is released, `bus_oe` is 0 and `bus_out` is 0x00. Every byte of the array then reads as 0xFF.
- R2: A normal read is selected when `sel_n`=0, `rd_n`=0, `pgm_hv`=0 and `id_hv`=0. The cycle after such a cycle, `bus_oe`=1 and `bus_out` equals the byte stored at `addr`.
- R3: Standby applies whenever `sel_n`=1 and `pgm_hv`=0. The cycle after it, `bus_oe`=0 and `bus_out`=0x00, whatever the value of `rd_n`.
- R4: Any of the following cycles leaves the bus undriven the next cycle and writes nothing:
  - `sel_n`=0 and `rd_n`=1 without `pgm_hv`.
  - `pgm_hv`=1, `sel_n`=0 and `rd_n`=1 with `pgm_n`=1.
  - `pgm_hv`=1, `sel_n`=0 and `rd_n`=0 with `pgm_n`=0.
- R5: A program cycle is `pgm_hv`=1, `rd_n`=1, `sel_n`=0 and `pgm_n`=0. It updates the byte at `addr` at that clock edge. No other byte changes, and the bus is undriven the following cycle.
- R6: A program cycle stores the bitwise AND of `wr_data` and the old byte. A 1 in `wr_data` never sets a cleared bit back to 1.
- R7: Program verify is `pgm_hv`=1, `sel_n`=0, `rd_n`=0 and `pgm_n`=1. The cycle after it, `bus_oe`=1 and `bus_out` is the stored byte, including any write made in the cycle before.
- R8: Program inhibit is `pgm_hv`=1 with `sel_n`=1. It leaves the array unchanged even when `pgm_n`=0, and leaves the bus undriven the next cycle.
- R9: Identifier mode is `id_hv`=1, `pgm_hv`=0, `sel_n`=0 and `rd_n`=0. In this mode, with `addr[1]`=1, the output the next cycle is 0x1C when `addr[0]`=0 and 0x02 when `addr[0]`=1.
- R10: In identifier mode with `addr[1]`=0, the output the next cycle is 0x7F, whatever the value of `addr[0]`.
- R11: Every identifier byte has an odd number of ones, with bit 7 serving as the parity bit. Address bits above bit 1 do not affect the identifier byte. Identifier mode writes nothing.
- R12: Whenever `bus_oe`=0, `bus_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| sel_n | input | 1 | Active-low device select |
| rd_n | input | 1 | Active-low read (output) strobe |
| pgm_n | input | 1 | Active-low program strobe |
| pgm_hv | input | 1 | Programming-voltage-present flag |
| id_hv | input | 1 | Identification-voltage-on-address-9 flag |
| addr | input | AW | Byte address (AW = log2 of DEPTH, at least 2) |
| wr_data | input | 8 | Byte to program |
| bus_out | output | 8 | Registered data output, 0x00 when not driven |
| bus_oe | output | 1 | Registered drive enable for the external tri-state pad |

## Verification
Every result is due exactly one clock edge after the cycle that requests it. Both the output register and the array write act on the same edge. As a result, a verify cycle placed right after a program cycle must already show the ANDed byte. The bench drives each stimulus just after a falling edge. It samples on the next falling edge, so exactly one rising edge lies between stimulus and check. When a requirement says something is not written, the bench reads the touched location back through a later read or verify cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_INHIBIT = 3'd1,
    MD_NODRIVE = 3'd2,
    MD_READ    = 3'd3,
    MD_IDENT   = 3'd4,
    MD_PROGRAM = 3'd5,
    MD_VERIFY  = 3'd6
  } op_mode_e;

  function automatic logic mode_drives(input op_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic     sel_n,
  input  logic     rd_n,
  input  logic     pgm_n,
  input  logic     pgm_hv,
  input  logic     id_hv,
  output op_mode_e mode,
  output logic     drive,
  output logic     wr_en,
  output logic     use_id
);

  always_comb begin
    mode = MD_NODRIVE;
    if (sel_n) begin
      mode = pgm_hv ? MD_INHIBIT : MD_STANDBY;
    end else if (pgm_hv) begin
      if (rd_n && !pgm_n)       mode = MD_PROGRAM;
      else if (!rd_n && pgm_n)  mode = MD_VERIFY;
      else                      mode = MD_NODRIVE;
    end else if (!rd_n) begin
      mode = id_hv ? MD_IDENT : MD_READ;
    end
  end

  always_comb begin
    drive  = mode_drives(mode);
    wr_en  = (mode == MD_PROGRAM);
    use_id = (mode == MD_IDENT);
  end

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
  import otp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h1C,
  parameter logic [BYTE_W-1:0] DEV_CODE  = 8'h02,
  parameter logic [BYTE_W-1:0] CONT_CODE = 8'h7F
) (
  input  logic              a1,
  input  logic              a0,
  output logic [BYTE_W-1:0] id_byte
);

  always_comb begin
    if (!a1)      id_byte = CONT_CODE;
    else if (a0)  id_byte = DEV_CODE;
    else          id_byte = MFR_CODE;
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] cell_q [DEPTH];
  logic [BYTE_W-1:0] cleared;

  always_comb begin
    rdata   = cell_q[addr];
    cleared = rdata & wdata;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic word_en;
    logic [BYTE_W-1:0] word_d;

    always_comb begin
      word_en = wr_en && (addr == AW'(i));
      word_d  = cleared;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[i] <= '1;
      else if (word_en) cell_q[i] <= word_d;
    end
  end

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              use_id,
  input  logic [BYTE_W-1:0] id_byte,
  input  logic [BYTE_W-1:0] cell_byte,
  output logic [BYTE_W-1:0] dq_q,
  output logic              oe_q
);

  logic [BYTE_W-1:0] dq_d;
  logic              oe_d;

  always_comb begin
    oe_d = drive;
    dq_d = '0;
    if (drive) dq_d = use_id ? id_byte : cell_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= dq_d;
      oe_q <= oe_d;
    end
  end

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              pgm_n,
  input  logic              pgm_hv,
  input  logic              id_hv,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe
);

  op_mode_e          mode;
  logic              drive;
  logic              wr_en;
  logic              use_id;
  logic [BYTE_W-1:0] id_byte;
  logic [BYTE_W-1:0] cell_byte;

  otp_mode_decode u_dec (
    .sel_n  (sel_n),
    .rd_n   (rd_n),
    .pgm_n  (pgm_n),
    .pgm_hv (pgm_hv),
    .id_hv  (id_hv),
    .mode   (mode),
    .drive  (drive),
    .wr_en  (wr_en),
    .use_id (use_id)
  );

  otp_id_rom u_id (
    .a1      (addr[1]),
    .a0      (addr[0]),
    .id_byte (id_byte)
  );

  otp_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wr_data),
    .rdata (cell_byte)
  );

  otp_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive     (drive),
    .use_id    (use_id),
    .id_byte   (id_byte),
    .cell_byte (cell_byte),
    .dq_q      (bus_out),
    .oe_q      (bus_oe)
  );

endmodule

// File: rtl/otp_byte_mem_chk.sv
module otp_byte_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       rd_n,
  input logic       pgm_n,
  input logic       pgm_hv,
  input logic       id_hv,
  input logic [7:0] bus_out,
  input logic       bus_oe
);

  assert_standby_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !pgm_hv) |=> (!bus_oe && bus_out == 8'h00));

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_n && !pgm_hv && !id_hv) |=> bus_oe);

  assert_program_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_hv && !sel_n && rd_n && !pgm_n) |=> !bus_oe);

  assert_verify_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_hv && !sel_n && !rd_n && pgm_n) |=> bus_oe);

  assert_inhibit_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_hv && sel_n) |=> !bus_oe);

  assert_id_odd_parity_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_n && !pgm_hv && id_hv) |=> (bus_oe && ^bus_out));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == 8'h00);

endmodule

bind otp_byte_mem otp_byte_mem_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .rd_n    (rd_n),
  .pgm_n   (pgm_n),
  .pgm_hv  (pgm_hv),
  .id_hv   (id_hv),
  .bus_out (bus_out),
  .bus_oe  (bus_oe)
);

// File: tb/tb_otp_byte_mem.sv
module tb_otp_byte_mem;

  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, rd_n, pgm_n, pgm_hv, id_hv;
  logic [AW-1:0] addr;
  logic [7:0]    wr_data;
  logic [7:0]    bus_out;
  logic          bus_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] shadow [DEPTH];

  always #2 clk = ~clk;

  otp_byte_mem #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .pgm_n(pgm_n),
    .pgm_hv(pgm_hv), .id_hv(id_hv), .addr(addr), .wr_data(wr_data),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  // drive one cycle of stimulus, then wait so one rising edge passes
  task automatic step(input logic s, input logic r, input logic p, input logic v,
                      input logic h, input logic [AW-1:0] a, input logic [7:0] d);
    sel_n = s; rd_n = r; pgm_n = p; pgm_hv = v; id_hv = h; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a);
    step(0, 0, 1, 0, 0, a, 8'h00);
    check(req, {bus_oe, bus_out}, {1'b1, shadow[a]});
  endtask

  task automatic do_verify(input string req, input logic [AW-1:0] a);
    step(0, 0, 1, 1, 0, a, 8'h00);
    check(req, {bus_oe, bus_out}, {1'b1, shadow[a]});
  endtask

  task automatic do_program(input string req, input logic [AW-1:0] a, input logic [7:0] d);
    step(0, 1, 0, 1, 0, a, d);
    shadow[a] = shadow[a] & d;
    check(req, {bus_oe, bus_out}, 9'h000);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(1, 1, 1, 0, 0, '0, 8'h00);
    @(negedge clk);
    check("R1 in reset", {bus_oe, bus_out}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {bus_oe, bus_out}, 9'h000);
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    do_read("R1 erased byte 0", 6'd0);
    do_read("R1 erased byte 37", 6'd37);
    do_read("R1 erased byte 63", 6'd63);
  endtask

  task automatic t_float;
    step(1, 0, 1, 0, 0, 6'd3, 8'h00);
    check("R3 standby rd low", {bus_oe, bus_out}, 9'h000);
    step(1, 1, 0, 0, 0, 6'd3, 8'h00);
    check("R3 standby rd high", {bus_oe, bus_out}, 9'h000);
    step(0, 1, 1, 0, 0, 6'd3, 8'h00);
    check("R4 read strobe off", {bus_oe, bus_out}, 9'h000);
    step(0, 1, 1, 1, 0, 6'd3, 8'h00);
    check("R4 hv both strobes high", {bus_oe, bus_out}, 9'h000);
    step(0, 0, 0, 1, 0, 6'd3, 8'h00);
    check("R4 hv both strobes low", {bus_oe, bus_out}, 9'h000);
    step(1, 0, 1, 0, 1, 6'd2, 8'h00);
    check("R12 deselected id flag", {bus_oe, bus_out}, 9'h000);
    do_verify("R4 no write at byte 3", 6'd3);
  endtask

  task automatic t_program;
    do_program("R5 program float", 6'd5, 8'hA5);
    do_verify("R7 verify after program", 6'd5);
    do_program("R5 second program", 6'd5, 8'hF0);
    do_verify("R6 and-merge A5&F0", 6'd5);
    check("R6 expected A0", {1'b0, shadow[5]}, 9'h0A0);
    do_program("R6 ones do not restore", 6'd5, 8'hFF);
    do_read("R6 still A0 via read", 6'd5);
    do_program("R5 top byte", 6'd63, 8'h3C);
    do_read("R2 read top byte", 6'd63);
    do_read("R5 neighbour 4 untouched", 6'd4);
    do_read("R5 neighbour 6 untouched", 6'd6);
    do_program("R5 byte 0", 6'd0, 8'h00);
    do_read("R2 read cleared byte", 6'd0);
  endtask

  task automatic t_inhibit;
    step(1, 1, 0, 1, 0, 6'd9, 8'h00);
    check("R8 inhibit float", {bus_oe, bus_out}, 9'h000);
    step(1, 0, 1, 1, 0, 6'd9, 8'h00);
    check("R8 inhibit with rd low", {bus_oe, bus_out}, 9'h000);
    do_verify("R8 byte 9 unchanged", 6'd9);
  endtask

  task automatic t_ident;
    step(0, 0, 1, 0, 1, 6'b000010, 8'h00);
    check("R9 manufacturer", {bus_oe, bus_out}, 9'h11C);
    step(0, 0, 1, 0, 1, 6'b000011, 8'h00);
    check("R9 device", {bus_oe, bus_out}, 9'h102);
    step(0, 0, 1, 0, 1, 6'b000000, 8'h00);
    check("R10 continuation a0 low", {bus_oe, bus_out}, 9'h17F);
    step(0, 0, 1, 0, 1, 6'b000001, 8'h00);
    check("R10 continuation a0 high", {bus_oe, bus_out}, 9'h17F);
    step(0, 0, 1, 0, 1, 6'b101110, 8'h00);
    check("R11 upper bits ignored mfr", {bus_oe, bus_out}, 9'h11C);
    n_chk++;
    if (^bus_out !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 parity: got %02h, expected odd parity", bus_out);
    end
    step(0, 0, 0, 0, 1, 6'b110111, 8'h00);
    check("R11 upper bits ignored dev", {bus_oe, bus_out}, 9'h102);
    do_read("R11 id wrote nothing", 6'd2);
    do_read("R2 byte 46 after id", 6'd46);
  endtask

  initial begin
    t_reset();
    t_float();
    t_program();
    t_inhibit();
    t_ident();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule